// File: doc/BRIEF.md
# Compare-Match Output Channel with Shadow Latch

This block is one output channel of a high-resolution timing unit. A free-running timer value, supplied from outside, is compared every cycle against a compare register that software loads one byte at a time. The output pin is not set directly by software. Software writes a shadow latch, and the output latch that drives the pin takes the shadow value only at the moment the timer equals the compare value. Software can therefore plan either edge, or no edge at all, for an exact timer count, with no jitter from CPU activity.

For as long as the compare signal is asserted, the two latches act as one transparent latch. A port write made while the timer sits on the compare value goes straight through to the pin. With the compare function disabled, the port bit behaves as an ordinary latch. Two read paths exist. One returns the shadow latch and serves read-modify-write sequences. The other returns the pin level.

Top module: `cmp_out_channel`

## Requirements
- R1: After a synchronous active-low reset, the pin and the shadow latch both read 1 and the compare register holds 0. With compare enabled and a timer value of 0, the compare signal is therefore high.
- R2: Bit 0 of `cmp_byte_we` loads `cmp_wdata` into compare bits 7:0, and bit 1 loads it into bits 15:8. A load is visible from the next cycle. The byte not selected keeps its value.
- R3: `match_o` is high exactly when `cmp_en` is 1 and `timer_val` equals the full 16-bit compare register. It follows the inputs in the same cycle.
- R4: With `cmp_en` at 1 and no match at a clock edge, a port write updates the shadow latch from the next cycle and leaves the pin unchanged.
- R5: At a clock edge where `match_o` is high and no port write is made, the pin takes the shadow value from the next cycle. It toggles if the two differ and holds if they are equal.
- R6: At a clock edge where `match_o` is high and a port write is made, the shadow latch and the pin both take the written value from the next cycle.
- R7: Transparency lasts for every cycle in which the timer stays equal to the compare value. Each write made during a long match reaches the pin one cycle later.
- R8: With `cmp_en` at 0, `match_o` stays low whatever the timer value, and a port write updates the shadow latch and the pin together from the next cycle.
- R9: `rd_data` returns the shadow latch when `rd_rmw` is 1 and the pin level when `rd_rmw` is 0, combinationally. A read-modify-write of the shadow that is made outside a match leaves the pin untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | 16 | Current free-running timer count |
| cmp_en | input | 1 | Enables compare-controlled output |
| cmp_byte_we | input | 2 | Per-byte write enables for the compare register |
| cmp_wdata | input | 8 | Byte written into the compare register |
| port_wr | input | 1 | Port bit write strobe |
| port_wdata | input | 1 | Port bit write value |
| rd_rmw | input | 1 | Read source: 1 shadow latch, 0 pin |
| rd_data | output | 1 | Selected read value |
| match_o | output | 1 | Compare signal |
| pin_out | output | 1 | Output latch driving the pin |

## Verification
A port write and a compare match can land on the same clock edge. That collision decides whether a write is held back in the shadow or passes straight to the pin. The bench runs a sweep over every combination of enable, match, write strobe, write value and preceding latch contents. It steers the timer onto or away from the compare value in the same cycle as the write. An arithmetic model of both latches predicts the pin and the two read paths for the following cycle. A long match held over several cycles, with alternating writes, checks that transparency persists.

// File: rtl/cmp_pkg.sv
// Package: shared widths and the read-source encoding for the compare channel.
// Assumes the timer width is a whole multiple of the byte width.
package cmp_pkg;
    parameter int unsigned TMR_W  = 16;
    parameter int unsigned BYTE_W = 8;

    typedef enum logic {
        RD_PIN    = 1'b0,
        RD_SHADOW = 1'b1
    } rd_src_e;
endpackage

// File: rtl/cmp_regfile.sv
// Compare register built from independently written bytes.
// Does: byte i of the register loads wdata when we[i] is high. Reset clears every byte.
// Assumes: W is a multiple of BW.
module cmp_regfile #(
    parameter int unsigned W  = 16,
    parameter int unsigned BW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W/BW-1:0]     we,
    input  logic [BW-1:0]       wdata,
    output logic [W-1:0]        value
);
    localparam int unsigned NB = W / BW;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [BW-1:0] byte_q;

        // Load one byte of the compare value on its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (we[i])
                byte_q <= wdata;
        end

        assign value[i*BW +: BW] = byte_q;
    end
endmodule

// File: rtl/cmp_comparator.sv
// Equality comparator producing the compare signal.
// Does: asserts hit while enabled and both operands are equal. The path is purely combinational.
// Assumes: the operands are stable for the setup time before each edge.
module cmp_comparator #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         en,
    output logic         hit
);
    // Gate the equality result with the channel enable.
    always_comb hit = en && (a == b);
endmodule

// File: rtl/port_dlatch.sv
// Double-latch port bit: shadow stage plus output stage.
// Does: writes always reach the shadow. The output stage loads on a match, taking write data
// when a write coincides with the match and the shadow otherwise. With compare disabled,
// a write loads both stages at once.
// Assumes: hit is already gated by the enable.
module port_dlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_en,
    input  logic hit,
    input  logic wr,
    input  logic wdata,
    output logic shadow_q,
    output logic out_q
);
    logic shadow_d;
    logic out_d;

    // Next shadow value: any write lands here.
    always_comb shadow_d = wr ? wdata : shadow_q;

    // Next output value: transparent on a match, plain latch when compare is off.
    always_comb begin
        out_d = out_q;
        if (hit)
            out_d = shadow_d;
        else if (!cmp_en && wr)
            out_d = wdata;
    end

    // Register both stages. Reset drives both to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= 1'b1;
            out_q    <= 1'b1;
        end else begin
            shadow_q <= shadow_d;
            out_q    <= out_d;
        end
    end
endmodule

// File: rtl/cmp_out_channel.sv
// Top: compare-match output channel with shadow latch.
// Does: compares an external timer against a byte-loaded compare register and updates the
// pin from a shadow latch on a match. Two read paths are offered: shadow and pin.
// Assumes: the timer is free running and supplied from outside; synchronous active-low reset.
module cmp_out_channel
    import cmp_pkg::*;
#(
    parameter int unsigned TW = cmp_pkg::TMR_W,
    parameter int unsigned BW = cmp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_val,
    input  logic              cmp_en,
    input  logic [TW/BW-1:0]  cmp_byte_we,
    input  logic [BW-1:0]     cmp_wdata,
    input  logic              port_wr,
    input  logic              port_wdata,
    input  logic              rd_rmw,
    output logic              rd_data,
    output logic              match_o,
    output logic              pin_out
);
    logic [TW-1:0] cmp_q;
    logic          shadow_q;
    rd_src_e       rd_src;

    cmp_regfile #(.W(TW), .BW(BW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmp_byte_we),
        .wdata (cmp_wdata),
        .value (cmp_q)
    );

    cmp_comparator #(.W(TW)) u_cmp (
        .a   (timer_val),
        .b   (cmp_q),
        .en  (cmp_en),
        .hit (match_o)
    );

    port_dlatch u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (cmp_en),
        .hit      (match_o),
        .wr       (port_wr),
        .wdata    (port_wdata),
        .shadow_q (shadow_q),
        .out_q    (pin_out)
    );

    // Select the read source: shadow for read-modify-write, pin for plain reads.
    always_comb begin
        rd_src  = rd_src_e'(rd_rmw);
        rd_data = (rd_src == RD_SHADOW) ? shadow_q : pin_out;
    end
endmodule

// File: rtl/cmp_out_channel_chk.sv
// Checker for cmp_out_channel: timing rules of the double latch and the compare gate.
// Assumes: bound into the top so that it can see the internal shadow_q.
module cmp_out_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic cmp_en,
    input logic match_o,
    input logic port_wr,
    input logic port_wdata,
    input logic pin_out,
    input logic shadow_q,
    input logic rd_rmw,
    input logic rd_data
);
    assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> !match_o);

    assert_pin_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !match_o) |=> $stable(pin_out));

    assert_match_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !port_wr) |=> (pin_out == $past(shadow_q)));

    assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && port_wr) |=> (pin_out == $past(port_wdata) && shadow_q == $past(port_wdata)));

    assert_plain_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && port_wr) |=> (pin_out == $past(port_wdata)));

    assert_read_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == (rd_rmw ? shadow_q : pin_out));
endmodule

bind cmp_out_channel cmp_out_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (cmp_en),
    .match_o    (match_o),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .pin_out    (pin_out),
    .shadow_q   (shadow_q),
    .rd_rmw     (rd_rmw),
    .rd_data    (rd_data)
);

// File: tb/cmp_out_channel_test.sv
module cmp_out_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic        cmp_en = 1'b0;
    logic [1:0]  cmp_byte_we = '0;
    logic [7:0]  cmp_wdata = '0;
    logic        port_wr = 1'b0;
    logic        port_wdata = 1'b0;
    logic        rd_rmw = 1'b0;
    logic        rd_data;
    logic        match_o;
    logic        pin_out;

    int checks = 0;
    int errors = 0;
    logic        m_sh, m_pin;
    logic [15:0] m_cmp;
    logic [15:0] lfsr = 16'hACE1;

    cmp_out_channel uut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cmp_en(cmp_en),
        .cmp_byte_we(cmp_byte_we), .cmp_wdata(cmp_wdata), .port_wr(port_wr),
        .port_wdata(port_wdata), .rd_rmw(rd_rmw), .rd_data(rd_data),
        .match_o(match_o), .pin_out(pin_out)
    );

    always #10 clk = ~clk;

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    // Check pin, both read paths against the model.
    task automatic chk_state(input string req);
        chk(req, pin_out, m_pin);
        rd_rmw = 1'b1; #1;
        chk({req, " R9 shadow read"}, rd_data, m_sh);
        rd_rmw = 1'b0; #1;
        chk({req, " R9 pin read"}, rd_data, m_pin);
    endtask

    // One cycle: drive, check the compare signal, clock, update the model.
    task automatic cyc(input logic en, input logic [15:0] tv, input logic wr, input logic d,
                       input string req);
        logic hit;
        cmp_en = en; timer_val = tv; port_wr = wr; port_wdata = d; #1;
        hit = en && (tv == m_cmp);
        chk("R3 compare signal", match_o, hit);
        @(posedge clk); #1;
        port_wr = 1'b0;
        if (hit) m_pin = wr ? d : m_sh;
        else if (!en && wr) m_pin = d;
        if (wr) m_sh = d;
        chk_state(req);
    endtask

    task automatic wr_cmp(input logic [1:0] we, input logic [7:0] b);
        cmp_byte_we = we; cmp_wdata = b;
        @(posedge clk); #1;
        cmp_byte_we = '0;
        if (we[0]) m_cmp[7:0]  = b;
        if (we[1]) m_cmp[15:8] = b;
    endtask

    initial begin
        m_sh = 1'b1; m_pin = 1'b1; m_cmp = '0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; cmp_en = 1'b1; timer_val = '0; #1;
        // R1 reset values
        chk("R1 pin after reset", pin_out, 1);
        chk_state("R1 latches after reset");
        chk("R1 compare cleared gives match at 0", match_o, 1);

        // R2 byte writes
        wr_cmp(2'b01, 8'h3C);
        timer_val = 16'h003C; #1;
        chk("R2 low byte loaded", match_o, 1);
        wr_cmp(2'b10, 8'h5A);
        timer_val = 16'h5A3C; #1;
        chk("R2 high byte loaded", match_o, 1);
        timer_val = 16'h003C; #1;
        chk("R2 full value used", match_o, 0);
        wr_cmp(2'b01, 8'h3D);
        timer_val = 16'h5A3D; #1;
        chk("R2 high byte kept", match_o, 1);

        // R3 gate with enable off
        cmp_en = 1'b0; #1;
        chk("R8 no match when disabled", match_o, 0);

        // R4 R5 R6 R8 sweep over every input combination from varied latch states
        for (int rep = 0; rep < 8; rep++) begin
            for (int k = 0; k < 16; k++) begin
                logic en, hit, wr, d;
                en = k[3]; hit = k[2]; wr = k[1]; d = k[0];
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                // Preset the latches through disabled-mode writes.
                cyc(1'b0, 16'h0000, 1'b1, lfsr[0], "R8 preset pin");
                cyc(1'b1, m_cmp ^ 16'h0100, 1'b1, lfsr[1], "R4 preset shadow");
                cyc(en, hit ? m_cmp : (m_cmp ^ {8'h00, lfsr[9:2]} ^ 16'h0001), wr, d,
                    en ? (hit ? (wr ? "R6 write at match" : "R5 load at match")
                              : "R4 write held back")
                       : "R8 plain latch");
            end
        end

        // R9 read-modify-write outside a match
        cyc(1'b0, 16'h0, 1'b1, 1'b0, "R8 setup");
        rd_rmw = 1'b1; #1;
        cyc(1'b1, m_cmp ^ 16'h0002, 1'b1, ~rd_data, "R9 rmw invert shadow");
        chk("R9 pin untouched by rmw", pin_out, 0);

        // R5 toggle and hold
        cyc(1'b1, m_cmp, 1'b0, 1'b0, "R5 toggle at match");
        chk("R5 pin toggled", pin_out, 1);
        cyc(1'b1, m_cmp ^ 16'h0004, 1'b0, 1'b0, "R4 idle");
        cyc(1'b1, m_cmp, 1'b0, 1'b0, "R5 hold at match");
        chk("R5 pin held", pin_out, 1);

        // R7 long match with alternating writes
        for (int c = 0; c < 6; c++)
            cyc(1'b1, m_cmp, 1'b1, c[0], "R7 long match transparency");
        cyc(1'b1, m_cmp ^ 16'h0008, 1'b1, 1'b1, "R7 end of match holds back");
        chk("R7 pin after match ends", pin_out, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule